// File: doc/BRIEF.md
# Discharge Short-Circuit Protection Controller

This block watches the discharge current of a battery pack and turns off the discharge switch when that current stays too high for too long. Each valid current sample is compared against a threshold chosen by a configuration byte. A trip happens when enough consecutive samples exceed the threshold. A trip sets a trip status, asserts a discharge-off output and adds one to a trip-event counter. That counter leaks away: it drops by one after each programmable number of seconds.

Repeated trips are escalated. When a trip brings the event counter up to a nonzero latch limit, the block enters a latched fault. A trip clears after a programmed number of seconds, or at once when load-detect recovery is enabled and no load is present. A latched fault clears only after its own reset time. The discharge switch is released only when neither condition is active. All timing is counted on a one-second tick supplied from outside. The current input is already scaled to the same units as the thresholds.

Top module: `scd_guard`

## Requirements
- R1: After a synchronous reset, trip_o, latch_o, alert_o and dsg_off_o are 0 and the event counter is 0.
- R2: A valid sample is over-limit only when cur_i is negative and its magnitude is strictly greater than 100 + 50 * cfg_i[2:0]. A positive current is never over-limit.
- R3: A trip event occurs on the edge that accepts the (cfg_i[7:4] + 1)-th consecutive over-limit valid sample. On that edge trip_o and dsg_off_o go to 1. A valid sample that is not over-limit restarts the count. Cycles without cur_vld_i neither count nor restart.
- R4: Each trip event adds one to the event counter. alert_o is 1 exactly when the counter is nonzero.
- R5: While the counter is nonzero, ticks are counted. On the dec_per_i-th tick the counter drops by one and the tick count restarts. A period of 0 acts as 1.
- R6: trip_o clears on the rec_time_i-th tick seen while it is set. A value of 0 acts as 1.
- R7: While trip_o is set, load_det_en_i = 1 with load_present_i = 0 clears trip_o at the next edge. This path has no effect on latch_o.
- R8: A trip event that brings the counter to at least a nonzero latch_lim_i sets latch_o, leaves trip_o at 0, and keeps dsg_off_o at 1.
- R9: With latch_lim_i = 0, latch_o never sets, however many trips occur.
- R10: latch_o clears on the rel_time_i-th tick seen while it is set. dsg_off_o is 0 only when trip_o and latch_o are both 0.
- R11: The event counter saturates at 255 and never wraps.
- R12: While dsg_off_o is 1, over-limit samples are not counted and cause no trip event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_i | input | CUR_W | Signed current sample; discharge is negative |
| cur_vld_i | input | 1 | cur_i holds a new sample this cycle |
| tick_1s_i | input | 1 | One-cycle pulse once per second |
| cfg_i | input | 8 | [2:0] threshold select, [7:4] persistence select |
| latch_lim_i | input | PAR_W | Counter value that escalates to latch; 0 disables latching |
| dec_per_i | input | PAR_W | Seconds per counter decrement |
| rec_time_i | input | PAR_W | Seconds before a trip clears |
| rel_time_i | input | PAR_W | Seconds before a latch clears |
| load_det_en_i | input | 1 | Enables early trip recovery on load removal |
| load_present_i | input | 1 | A load is still attached |
| trip_o | output | 1 | Trip status |
| latch_o | output | 1 | Latched fault status |
| alert_o | output | 1 | Event counter is nonzero |
| dsg_off_o | output | 1 | Discharge switch disable |

## Verification
The detector is tested with several over-limit runs. A clean run trips on exactly the selected sample. A run broken by an at-threshold sample or a positive sample must start over. A run with gaps where no sample is valid must keep counting. Samples one unit on either side of a non-default threshold show whether the comparison is strict. Trip sequences with different latch limits test escalation, the zero-limit case, the fact that detection is blocked while the switch is off, and saturation: after 300 trips the counter must take exactly 255 one-second decrements to reach zero.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // configuration byte: persistence select high, threshold select low
  typedef struct packed {
    logic [3:0] dly_sel;
    logic       spare;
    logic [2:0] thr_sel;
  } scd_cfg_t;

  // roles of the second-based timers
  typedef enum int {
    TMR_REC = 0,
    TMR_REL = 1,
    TMR_DEC = 2
  } scd_tmr_e;

  localparam int SCD_NUM_TMR = 3;
endpackage

// File: rtl/scd_detect.sv
module scd_detect
  import scd_pkg::*;
#(
  parameter int CUR_W    = 16,
  parameter int THR_BASE = 100,
  parameter int THR_STEP = 50,
  parameter int DLY_UNIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic [CUR_W-1:0] cur_i,
  input  logic             vld_i,
  input  logic [7:0]       cfg_i,
  output logic             evt_o
);
  localparam int MAX_N = 16 * DLY_UNIT;
  localparam int DW    = $clog2(MAX_N + 1);

  scd_cfg_t         cfg;
  logic [CUR_W:0]   ext, mag, thr;
  logic [DW:0]      need, nxt;
  logic [DW-1:0]    run_q;
  logic             over;

  always_comb begin
    cfg  = scd_cfg_t'(cfg_i);
    thr  = (CUR_W+1)'(THR_BASE + THR_STEP * int'(cfg.thr_sel));
    need = (DW+1)'((int'(cfg.dly_sel) + 1) * DLY_UNIT);
    ext  = {cur_i[CUR_W-1], cur_i};
    mag  = cur_i[CUR_W-1] ? (~ext + 1'b1) : '0;
    over = cur_i[CUR_W-1] && (mag > thr);
    nxt  = {1'b0, run_q} + 1'b1;
    evt_o = vld_i && !hold_i && over && (nxt >= need);
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      run_q <= '0;
    end else if (vld_i) begin
      if (!over || evt_o) run_q <= '0;
      else                run_q <= nxt[DW-1:0];
    end
  end
endmodule

// File: rtl/scd_sec_timer.sv
module scd_sec_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  always_comb begin
    nxt    = {1'b0, cnt_q} + 1'b1;
    done_o = run_i && tick_i && (nxt >= {1'b0, len_i});
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i || done_o) cnt_q <= '0;
    else if (tick_i)             cnt_q <= nxt[W-1:0];
  end
endmodule

// File: rtl/scd_guard.sv
module scd_guard
  import scd_pkg::*;
#(
  parameter int CUR_W    = 16,
  parameter int PAR_W    = 8,
  parameter int THR_BASE = 100,
  parameter int THR_STEP = 50,
  parameter int DLY_UNIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CUR_W-1:0] cur_i,
  input  logic             cur_vld_i,
  input  logic             tick_1s_i,
  input  logic [7:0]       cfg_i,
  input  logic [PAR_W-1:0] latch_lim_i,
  input  logic [PAR_W-1:0] dec_per_i,
  input  logic [PAR_W-1:0] rec_time_i,
  input  logic [PAR_W-1:0] rel_time_i,
  input  logic             load_det_en_i,
  input  logic             load_present_i,
  output logic             trip_o,
  output logic             latch_o,
  output logic             alert_o,
  output logic             dsg_off_o
);
  localparam logic [PAR_W-1:0] CNT_MAX = '1;

  logic                   evt;
  logic [PAR_W-1:0]       cnt_q, cnt_n;
  logic                   trip_n, latch_n;
  logic [SCD_NUM_TMR-1:0] run, done;
  logic [PAR_W-1:0]       len [SCD_NUM_TMR];

  scd_detect #(
    .CUR_W(CUR_W), .THR_BASE(THR_BASE), .THR_STEP(THR_STEP), .DLY_UNIT(DLY_UNIT)
  ) u_det (
    .clk(clk), .rst(rst), .hold_i(dsg_off_o), .cur_i(cur_i),
    .vld_i(cur_vld_i), .cfg_i(cfg_i), .evt_o(evt)
  );

  always_comb begin
    run[TMR_REC] = trip_o;
    run[TMR_REL] = latch_o;
    run[TMR_DEC] = (cnt_q != '0);
    len[TMR_REC] = rec_time_i;
    len[TMR_REL] = rel_time_i;
    len[TMR_DEC] = dec_per_i;
  end

  for (genvar g = 0; g < SCD_NUM_TMR; g++) begin : g_tmr
    scd_sec_timer #(.W(PAR_W)) u_tmr (
      .clk(clk), .rst(rst), .run_i(run[g]), .tick_i(tick_1s_i),
      .len_i(len[g]), .done_o(done[g])
    );
  end

  always_comb begin
    cnt_n = cnt_q;
    if (evt && !done[TMR_DEC])      cnt_n = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    else if (!evt && done[TMR_DEC]) cnt_n = cnt_q - 1'b1;

    trip_n  = trip_o;
    latch_n = latch_o;
    if (trip_o && (done[TMR_REC] || (load_det_en_i && !load_present_i))) trip_n = 1'b0;
    if (latch_o && done[TMR_REL]) latch_n = 1'b0;
    if (evt) begin
      if (latch_lim_i != '0 && cnt_n >= latch_lim_i) begin
        latch_n = 1'b1;
        trip_n  = 1'b0;
      end else begin
        trip_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      trip_o    <= 1'b0;
      latch_o   <= 1'b0;
      alert_o   <= 1'b0;
      dsg_off_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      trip_o    <= trip_n;
      latch_o   <= latch_n;
      alert_o   <= (cnt_n != '0);
      dsg_off_o <= trip_n | latch_n;
    end
  end
endmodule

// File: rtl/scd_guard_chk.sv
module scd_guard_chk #(
  parameter int PAR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cur_vld_i,
  input logic             tick_1s_i,
  input logic [PAR_W-1:0] latch_lim_i,
  input logic             load_det_en_i,
  input logic             load_present_i,
  input logic             trip_o,
  input logic             latch_o,
  input logic             alert_o,
  input logic             dsg_off_o
);
  // R8
  trip_latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(trip_o && latch_o));

  // R3
  trip_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> $past(cur_vld_i));

  // R5
  alert_fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_o) |-> $past(tick_1s_i));

  // R6
  trip_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(trip_o) |-> ($past(tick_1s_i) || $past(load_det_en_i && !load_present_i)));

  // R8
  latch_rise_clears_trip_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_o) |-> (!trip_o && dsg_off_o));

  // R9
  latch_needs_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_o) |-> ($past(latch_lim_i) != '0));

  // R10
  release_both_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dsg_off_o) |-> (!trip_o && !latch_o));

  // R10
  latch_fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_o) |-> $past(tick_1s_i));
endmodule

bind scd_guard scd_guard_chk #(.PAR_W(PAR_W)) u_chk (
  .clk(clk), .rst(rst), .cur_vld_i(cur_vld_i), .tick_1s_i(tick_1s_i),
  .latch_lim_i(latch_lim_i), .load_det_en_i(load_det_en_i),
  .load_present_i(load_present_i), .trip_o(trip_o), .latch_o(latch_o),
  .alert_o(alert_o), .dsg_off_o(dsg_off_o)
);

// File: tb/scd_guard_bench.sv
`timescale 1ns/100ps
module scd_guard_bench;
  logic              clk = 1'b0;
  logic              rst;
  logic signed [15:0] cur;
  logic              vld, tick, lden, load;
  logic [7:0]        cfg, lim, dec, rec, rel;
  logic              trip, latch, alert, dsg;
  int                n_chk = 0, n_fail = 0;
  bit                done_flag = 0;

  always #2.5 clk = ~clk;

  scd_guard u_scd_guard (
    .clk(clk), .rst(rst), .cur_i(cur), .cur_vld_i(vld), .tick_1s_i(tick),
    .cfg_i(cfg), .latch_lim_i(lim), .dec_per_i(dec), .rec_time_i(rec),
    .rel_time_i(rel), .load_det_en_i(lden), .load_present_i(load),
    .trip_o(trip), .latch_o(latch), .alert_o(alert), .dsg_off_o(dsg)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cur = '0; vld = 0; tick = 0; lden = 0; load = 1;
    cfg = 8'h00; lim = 0; dec = 8'd255; rec = 8'd255; rel = 8'd255;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
  endtask

  task automatic sample(input int val);
    @(negedge clk); cur = 16'(val); vld = 1;
    @(posedge clk); #1; vld = 0;
  endtask

  task automatic idle();
    @(negedge clk); vld = 0;
    @(posedge clk); #1;
  endtask

  task automatic sec_tick();
    @(negedge clk); tick = 1;
    @(posedge clk); #1; tick = 0;
  endtask

  task automatic load_off();
    @(negedge clk); lden = 1; load = 0;
    @(posedge clk); #1; load = 1; lden = 0;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 trip", trip, 0); chk("R1 latch", latch, 0);
    chk("R1 alert", alert, 0); chk("R1 dsg", dsg, 0);
  endtask

  task automatic t_persist();
    do_reset(); cfg = 8'h20;            // need 3 samples above 100
    sample(-150); sample(-150);
    chk("R3 two samples", trip, 0);
    sample(-100);                       // equal: not over (R2)
    sample(-150); sample(-150);
    chk("R2 equal restarts", trip, 0);
    sample(500);                        // positive: not over
    sample(-150); sample(-150);
    chk("R2 positive restarts", trip, 0);
    idle();                             // gap does not restart
    sample(-150);
    chk("R3 trip on third", trip, 1);
    chk("R3 dsg", dsg, 1);
    chk("R4 alert", alert, 1);
  endtask

  task automatic t_threshold();
    do_reset(); cfg = 8'h03;            // threshold 250, one sample
    sample(-250);
    chk("R2 at 250", trip, 0);
    sample(-251);
    chk("R2 above 250", trip, 1);
  endtask

  task automatic t_timed_rec();
    do_reset(); rec = 8'd2;
    sample(-200);
    sec_tick();
    chk("R6 one tick", trip, 1);
    sec_tick();
    chk("R6 two ticks", trip, 0);
    chk("R10 released", dsg, 0);
    chk("R4 alert kept", alert, 1);
  endtask

  task automatic t_load_rec();
    do_reset();
    sample(-200);
    load_off();
    chk("R7 load removal", trip, 0);
    chk("R7 dsg", dsg, 0);
  endtask

  task automatic t_decrement();
    do_reset(); dec = 8'd3;
    sample(-200);
    load_off();
    sec_tick(); sec_tick();
    chk("R5 before period", alert, 1);
    sec_tick();
    chk("R5 after period", alert, 0);
  endtask

  task automatic t_latch();
    do_reset(); lim = 8'd2; rel = 8'd2;
    sample(-200);
    chk("R8 first trip no latch", latch, 0);
    load_off();
    sample(-200);
    chk("R8 latch", latch, 1);
    chk("R8 trip clear", trip, 0);
    chk("R8 dsg", dsg, 1);
    load_off();
    chk("R7 latch unaffected", latch, 1);
    sec_tick();
    chk("R10 one tick", latch, 1);
    sec_tick();
    chk("R10 latch reset", latch, 0);
    chk("R10 released", dsg, 0);
  endtask

  task automatic t_no_limit();
    do_reset();
    for (int i = 0; i < 5; i++) begin
      sample(-200);
      chk("R9 no latch", latch, 0);
      load_off();
    end
  endtask

  task automatic t_suppress();
    do_reset(); lim = 8'd2;
    sample(-200);
    for (int i = 0; i < 10; i++) sample(-200);
    chk("R12 no extra trip", latch, 0);
    load_off();
    chk("R12 latch still clear", latch, 0);
    sample(-200);
    chk("R12 second trip latches", latch, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 300; i++) begin
      sample(-200);
      load_off();
    end
    dec = 8'd1;
    for (int i = 0; i < 254; i++) sec_tick();
    chk("R11 after 254", alert, 1);
    sec_tick();
    chk("R11 after 255", alert, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1;
    t_reset();
    t_persist();
    t_threshold();
    t_timed_rec();
    t_load_rec();
    t_decrement();
    t_latch();
    t_no_limit();
    t_suppress();
    t_saturate();
    finish_run();
  end
endmodule